// File: doc/BRIEF.md
# Private Peripheral Space Security Decoder

This block sits between a processor's load/store port and the registers in its 1 MB private peripheral space. The space is addressed here by a 20-bit offset from the space's base. Each request carries two attributes: a secure bit and a user (unprivileged) bit. The decoder picks one target and drives it through a shared request bus plus a one-hot select. The targets are the system-register block, the non-secure tick-timer bank, the secure tick-timer bank and an optional error-record (RAS) register block. An address that no target claims is answered by a built-in responder. That responder reads as zero for privileged requests and signals a bus error for user requests.

Where windows overlap, a fixed priority decides. The tick-timer window sits inside the system-register block and takes precedence over it. Both take precedence over the fallback responder. When the security extension is built in, a second copy of the system-register block appears 0x20000 bytes above the main one. It is a non-secure view. A secure request there is moved down to the same offset in the main block with its secure attribute cleared. A non-secure request there gets the fallback answer. Target answers travel back unchanged and complete in the cycle the target raises its ready. The requester holds its request until the response arrives.

Top module: `periph_sec_decoder`

## Requirements
- R1: Offsets 0xE000–0xEFFF that lie outside 0xE010–0xE0EF select the system-register target (tgt_sel bit 0), with address, secure and user passed unchanged.
- R2: Offsets 0xE010–0xE0EF select a tick-timer bank, overriding R1: the secure bank (tgt_sel bit 2) when req_secure is 1 and the security extension is built in, otherwise the non-secure bank (tgt_sel bit 1).
- R3: An offset claimed by no target selects nothing, so a write changes no target. One cycle after the request the block raises resp_valid with resp_rdata = 0 and resp_err = req_user.
- R4: With the security extension, a secure request to 0x2E000–0x2EFFF is forwarded with tgt_addr = req_addr − 0x20000 and tgt_secure = 0. It goes to the non-secure tick bank for 0x2E010–0x2E0EF and to the system-register target otherwise.
- R5: A non-secure request to 0x2E000–0x2EFFF selects nothing and gets the fallback answer of R3.
- R6: With the RAS block built in, offsets 0x5000–0x5FFF select it (tgt_sel bit 3).
- R7: A routed request completes (resp_valid = 1) in exactly the cycle its selected target has tgt_rdy high. resp_rdata and resp_err are that target's values. Ready from unselected targets is ignored.
- R8: tgt_sel is zero or one-hot, is zero without req_valid, and tgt_write, tgt_wdata and tgt_user equal the request's values.
- R9: While rst is high, resp_valid stays 0 for unclaimed requests, and tgt_sel is 0 when no request is present.
- R10: A held unclaimed request is answered with single-cycle pulses separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until resp_valid |
| req_addr | input | 20 | Offset within the peripheral space |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| resp_valid | output | 1 | Request completes this cycle |
| resp_rdata | output | DW | Read data |
| resp_err | output | 1 | Bus error |
| tgt_sel | output | 4 | One-hot target select: 0 sysreg, 1 tick NS, 2 tick S, 3 RAS |
| tgt_addr | output | 20 | Offset to target (alias moved down) |
| tgt_write | output | 1 | Write flag to target |
| tgt_wdata | output | DW | Write data to target |
| tgt_secure | output | 1 | Secure attribute to target (after rewrite) |
| tgt_user | output | 1 | Unprivileged attribute to target |
| tgt_rdy | input | 4 | Per-target ready |
| tgt_rdata | input | 4*DW | Per-target read data, target i at bits i*DW |
| tgt_err | input | 4 | Per-target error |

## Verification
The hardest cases to reach are the edges of nested windows. These are the first and last words of the tick window inside the system block, and the same edges in the alias copy. There, one address step flips both the target and the attribute rewrite. The stimulus sweeps the whole space coarsely under all four attribute combinations, then steps word by word across every window boundary. A second hard case is the fallback responder's pulse spacing under a held request. It is reached by keeping one unclaimed request up for three edges.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int AW      = 20;
  localparam int NUM_TGT = 4;
  localparam int NUM_WIN = 5;

  typedef enum logic [1:0] {
    TGT_SREG    = 2'd0,
    TGT_TICK_NS = 2'd1,
    TGT_TICK_S  = 2'd2,
    TGT_RAS     = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    WIN_TICK  = 3'd0,
    WIN_SREG  = 3'd1,
    WIN_ATICK = 3'd2,
    WIN_ASREG = 3'd3,
    WIN_RAS   = 3'd4
  } win_e;

  localparam logic [AW-1:0] WIN_BASE [NUM_WIN] =
    '{20'h0E010, 20'h0E000, 20'h2E010, 20'h2E000, 20'h05000};
  localparam logic [AW-1:0] WIN_SIZE [NUM_WIN] =
    '{20'h000E0, 20'h01000, 20'h000E0, 20'h01000, 20'h01000};
  localparam logic [AW-1:0] ALIAS_DELTA = 20'h20000;
endpackage

// File: rtl/psd_win_hit.sv
`timescale 1ns/1ps
module psd_win_hit #(
  parameter int            AW   = 20,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] SIZE = '0,
  parameter bit            EN   = 1'b1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] LO = {1'b0, BASE};
  localparam logic [AW:0] HI = {1'b0, BASE} + {1'b0, SIZE};

  always_comb begin
    hit = EN && ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
  end
endmodule

// File: rtl/psd_route.sv
`timescale 1ns/1ps
module psd_route
  import psd_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic               req_valid,
  input  logic [AW-1:0]      addr,
  input  logic               secure,
  input  logic [NUM_WIN-1:0] win_hit,
  output logic [NUM_TGT-1:0] sel,
  output logic               dflt,
  output logic [AW-1:0]      fwd_addr,
  output logic               fwd_secure
);
  always_comb begin
    sel        = '0;
    dflt       = 1'b0;
    fwd_addr   = addr;
    fwd_secure = secure;
    if (req_valid) begin
      if (win_hit[WIN_TICK]) begin
        if (SEC_EXT && secure) sel[TGT_TICK_S]  = 1'b1;
        else                   sel[TGT_TICK_NS] = 1'b1;
      end else if (win_hit[WIN_SREG]) begin
        sel[TGT_SREG] = 1'b1;
      end else if (win_hit[WIN_ATICK] || win_hit[WIN_ASREG]) begin
        if (secure) begin
          fwd_addr   = addr - ALIAS_DELTA;
          fwd_secure = 1'b0;
          if (win_hit[WIN_ATICK]) sel[TGT_TICK_NS] = 1'b1;
          else                    sel[TGT_SREG]    = 1'b1;
        end else begin
          dflt = 1'b1;
        end
      end else if (win_hit[WIN_RAS]) begin
        sel[TGT_RAS] = 1'b1;
      end else begin
        dflt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_dflt_rsp.sv
`timescale 1ns/1ps
module psd_dflt_rsp (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic user,
  output logic rsp_valid,
  output logic rsp_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= hit && !rsp_valid;
      rsp_err   <= hit && user;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r3_err_from_user: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_err == $past(user)));
  a_r3_after_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(hit));
endmodule

// File: rtl/periph_sec_decoder.sv
`timescale 1ns/1ps
module periph_sec_decoder
  import psd_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit SEC_EXT = 1'b1,
  parameter bit HAS_RAS = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [19:0]           req_addr,
  input  logic                  req_write,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  req_secure,
  input  logic                  req_user,
  output logic                  resp_valid,
  output logic [DW-1:0]         resp_rdata,
  output logic                  resp_err,
  output logic [3:0]            tgt_sel,
  output logic [19:0]           tgt_addr,
  output logic                  tgt_write,
  output logic [DW-1:0]         tgt_wdata,
  output logic                  tgt_secure,
  output logic                  tgt_user,
  input  logic [3:0]            tgt_rdy,
  input  logic [4*DW-1:0]       tgt_rdata,
  input  logic [3:0]            tgt_err
);
  localparam bit WIN_EN [NUM_WIN] = '{1'b1, 1'b1, SEC_EXT, SEC_EXT, HAS_RAS};

  logic [NUM_WIN-1:0] win_hit;
  logic               dflt_hit;
  logic               dflt_v;
  logic               dflt_e;
  logic [NUM_TGT-1:0] done_vec;
  logic [DW-1:0]      mux_data;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    psd_win_hit #(
      .AW  (AW),
      .BASE(WIN_BASE[g]),
      .SIZE(WIN_SIZE[g]),
      .EN  (WIN_EN[g])
    ) u_hit (
      .addr(req_addr),
      .hit (win_hit[g])
    );
  end

  psd_route #(.SEC_EXT(SEC_EXT)) u_route (
    .req_valid (req_valid),
    .addr      (req_addr),
    .secure    (req_secure),
    .win_hit   (win_hit),
    .sel       (tgt_sel),
    .dflt      (dflt_hit),
    .fwd_addr  (tgt_addr),
    .fwd_secure(tgt_secure)
  );

  psd_dflt_rsp u_dflt (
    .clk      (clk),
    .rst      (rst),
    .hit      (dflt_hit),
    .user     (req_user),
    .rsp_valid(dflt_v),
    .rsp_err  (dflt_e)
  );

  assign tgt_write = req_write;
  assign tgt_wdata = req_wdata;
  assign tgt_user  = req_user;
  assign done_vec  = tgt_sel & tgt_rdy;

  always_comb begin
    mux_data = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (done_vec[i]) mux_data = mux_data | tgt_rdata[i*DW +: DW];
    end
  end

  always_comb begin
    if (|done_vec) begin
      resp_valid = 1'b1;
      resp_rdata = mux_data;
      resp_err   = |(done_vec & tgt_err);
    end else begin
      resp_valid = dflt_v;
      resp_rdata = '0;
      resp_err   = dflt_v && dflt_e;
    end
  end

  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));
  a_r8_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (tgt_sel == '0));
  a_r2_secure_bank: assert property (@(posedge clk) disable iff (rst)
    tgt_sel[TGT_TICK_S] |-> req_secure);
  a_r4_alias_clears_secure: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr[19:12] == 8'h2E) && (tgt_sel != '0)) |-> !tgt_secure);
  a_r7_resp_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !dflt_v) |-> ((tgt_sel & tgt_rdy) != '0));
  a_r3_dflt_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && (tgt_sel == '0)) |-> (resp_rdata == '0));
endmodule

// File: tb/tb_periph_sec_decoder.sv
`timescale 1ns/1ps
module tb_periph_sec_decoder;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [19:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_secure = 1'b0;
  logic          req_user = 1'b0;
  logic          resp_valid;
  logic [DW-1:0] resp_rdata;
  logic          resp_err;
  logic [3:0]    tgt_sel;
  logic [19:0]   tgt_addr;
  logic          tgt_write;
  logic [DW-1:0] tgt_wdata;
  logic          tgt_secure;
  logic          tgt_user;
  logic [3:0]    tgt_rdy = 4'b1111;
  logic [4*DW-1:0] tgt_rdata;
  logic [3:0]    tgt_err = 4'b1010;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  assign tgt_rdata = {32'hD00D_0003, 32'hD00D_0002, 32'hD00D_0001, 32'hD00D_0000};

  always #2.5 clk = ~clk;

  periph_sec_decoder #(.DW(DW), .SEC_EXT(1'b1), .HAS_RAS(1'b1)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_user(req_user),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .tgt_sel(tgt_sel), .tgt_addr(tgt_addr), .tgt_write(tgt_write),
    .tgt_wdata(tgt_wdata), .tgt_secure(tgt_secure), .tgt_user(tgt_user),
    .tgt_rdy(tgt_rdy), .tgt_rdata(tgt_rdata), .tgt_err(tgt_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s addr=%h sec=%0b usr=%0b act=%h exp=%h",
               tag, req_addr, req_secure, req_user, act, exp);
    end
  endtask

  function automatic bit in_win(input int unsigned a, input int unsigned b, input int unsigned s);
    return (a >= b) && (a < b + s);
  endfunction

  // Expected routing worked out from the requirements.
  task automatic model(input int unsigned a, input bit sec, output logic [3:0] s,
                       output logic [19:0] fa, output bit fs, output string tag);
    s = 4'b0000; fa = a[19:0]; fs = sec; tag = "R3";
    if (in_win(a, 'hE010, 'hE0)) begin
      s = sec ? 4'b0100 : 4'b0010; tag = "R2";
    end else if (in_win(a, 'hE000, 'h1000)) begin
      s = 4'b0001; tag = "R1";
    end else if (in_win(a, 'h2E000, 'h1000)) begin
      if (sec) begin
        int unsigned m;
        m = a - 'h20000;
        fa = m[19:0]; fs = 1'b0; tag = "R4";
        s = in_win(m, 'hE010, 'hE0) ? 4'b0010 : 4'b0001;
      end else begin
        tag = "R5";
      end
    end else if (in_win(a, 'h5000, 'h1000)) begin
      s = 4'b1000; tag = "R6";
    end
  endtask

  task automatic access(input int unsigned a, input bit sec, input bit usr);
    logic [3:0]  es;
    logic [19:0] ea;
    bit          efs;
    string       tag;
    int          idx;
    model(a, sec, es, ea, efs, tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a[19:0];
    req_secure = sec;
    req_user   = usr;
    req_write  = a[2] ^ sec;
    req_wdata  = 32'h5A00_0000 | a;
    #1;
    chk(tgt_sel == es, tag, {28'd0, tgt_sel}, {28'd0, es});
    if (es != 4'b0000) begin
      idx = (es == 4'b0001) ? 0 : (es == 4'b0010) ? 1 : (es == 4'b0100) ? 2 : 3;
      chk(tgt_addr == ea, tag, {12'd0, tgt_addr}, {12'd0, ea});
      chk(tgt_secure == efs, tag, {31'd0, tgt_secure}, {31'd0, efs});
      chk(tgt_user == usr && tgt_write == req_write && tgt_wdata == req_wdata,
          "R8", {31'd0, tgt_user}, {31'd0, usr});
      chk(resp_valid == 1'b1, "R7", {31'd0, resp_valid}, 32'd1);
      chk(resp_rdata == 32'hD00D_0000 + idx, "R7", resp_rdata, 32'hD00D_0000 + idx);
      chk(resp_err == tgt_err[idx], "R7", {31'd0, resp_err}, {31'd0, tgt_err[idx]});
    end else begin
      chk(resp_valid == 1'b0, tag, {31'd0, resp_valid}, 32'd0);
      @(posedge clk); #1;
      chk(resp_valid == 1'b1, tag, {31'd0, resp_valid}, 32'd1);
      chk(resp_rdata == '0, tag, resp_rdata, 32'd0);
      chk(resp_err == usr, tag, {31'd0, resp_err}, {31'd0, usr});
      chk(tgt_sel == 4'b0000, tag, {28'd0, tgt_sel}, 32'd0);
    end
    req_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic sweep(input int unsigned lo, input int unsigned hi, input int unsigned step);
    for (int unsigned a = lo; a < hi; a += step) begin
      for (int k = 0; k < 4; k++) access(a, k[0], k[1]);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R9: reset state, including a held unclaimed request
    repeat (2) @(posedge clk);
    #1;
    chk(tgt_sel == 4'b0000, "R9", {28'd0, tgt_sel}, 32'd0);
    chk(resp_valid == 1'b0, "R9", {31'd0, resp_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h01000; req_user = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(resp_valid == 1'b0, "R9", {31'd0, resp_valid}, 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b0; req_user = 1'b0;
    rst = 1'b0;
    @(posedge clk);

    // Coarse sweep of the whole space, all attribute combinations
    sweep(0, 'h100000, 'h100);
    // Word-by-word across every window edge
    sweep('hDFF0, 'hE110, 4);
    sweep('hEFF0, 'hF010, 4);
    sweep('h2DFF0, 'h2E110, 4);
    sweep('h2EFF0, 'h2F010, 4);
    sweep('h4FF0, 'h5010, 4);
    sweep('h5FF0, 'h6010, 4);

    // R10: held unclaimed request gives spaced pulses
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h00200; req_secure = 1'b0; req_user = 1'b0;
    @(posedge clk); #1;
    chk(resp_valid == 1'b1, "R10", {31'd0, resp_valid}, 32'd1);
    @(posedge clk); #1;
    chk(resp_valid == 1'b0, "R10", {31'd0, resp_valid}, 32'd0);
    @(posedge clk); #1;
    chk(resp_valid == 1'b1, "R10", {31'd0, resp_valid}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);

    // R7: completion waits for the selected target's ready
    @(negedge clk);
    tgt_rdy = 4'b1110;
    req_valid = 1'b1; req_addr = 20'h0E100; req_secure = 1'b1; req_user = 1'b0;
    #1;
    chk(resp_valid == 1'b0, "R7", {31'd0, resp_valid}, 32'd0);
    @(negedge clk);
    tgt_rdy = 4'b1111;
    #1;
    chk(resp_valid == 1'b1 && resp_rdata == 32'hD00D_0000, "R7", resp_rdata, 32'hD00D_0000);
    @(negedge clk);
    tgt_rdy = 4'b0001;
    req_addr = 20'h0E020; req_secure = 1'b0;
    #1;
    chk(resp_valid == 1'b0, "R7", {31'd0, resp_valid}, 32'd0);
    @(negedge clk);
    tgt_rdy = 4'b0010;
    #1;
    chk(resp_valid == 1'b1 && resp_err == 1'b1, "R7", {31'd0, resp_err}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    tgt_rdy = 4'b1111;
    #1;
    chk(tgt_sel == 4'b0000, "R8", {28'd0, tgt_sel}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule